// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Bank

This block keeps the reset line and the clock-stop line of every peripheral in a chip in four 32-bit control words. Two words hold 64 reset lines and two hold 64 clock-stop lines. Software never rewrites a whole word. Each word has a set address and a clear address 4 bytes above it. Writing ones to the set address raises those bits, and writing ones to the clear address lowers them. Because of this, separate agents can change their own lines without a read-modify-write race.

A line number below 32 lives in the first word of its kind, and any other line lives in the second word, at bit position (line mod 32). A reset bit at 1 holds its peripheral in reset. A clock-stop bit at 1 halts that clock, with one exception: line 14 has the opposite sense, so a 1 on line 14 lets its clock run. Bit 31 of the first clock-stop word is not a clock. It selects a divide-by-13 reference for one group of serial ports. Any offset that is not decoded ignores writes and reads back zero.

Top module: `sc_ctl_bank`

## Requirements
- R1: After the synchronous reset, every implemented reset bit and every implemented clock-stop bit is 1, except clock line 14, which is 0. The divide-by-13 select (clock word 0, bit 31) is therefore 1.
- R2: A write to a set address (reset words 0x040 and 0x050, clock words 0x080 and 0x090) raises each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A write to a clear address (set address + 0x4) lowers each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: Line n maps to word 0 of its kind when n < 32 and to word 1 otherwise, at bit n mod 32. `periph_rst[n]` and `clk_run[n]` follow that bit.
- R5: `periph_rst[n]` equals the stored reset bit for line n. A value of 1 means the peripheral is held in reset.
- R6: `clk_run[n]` is the inverse of the stored clock-stop bit for every implemented clock line except line 14. For line 14, `clk_run[14]` equals the stored bit.
- R7: `uart_div13` equals clock word 0 bit 31, and `clk_run[31]` is always 0.
- R8: Clock lines that are not implemented are tied off: they ignore writes, read as 0, and drive `clk_run` 0. The implemented masks are 0x8B30E6FF for word 0 and 0x7FFFFF37 for word 1. All 64 reset lines are implemented.
- R9: A read of a clear address returns the same value as the set address of the same word.
- R10: A write to any other offset, including an offset that is not 4-byte aligned, changes no state. A read of such an offset returns 0.
- R11: `rd_data` is registered on the edge that samples `rd_en` and holds its value while `rd_en` is low. State changes on the edge that samples the write. The outputs show the new state one edge later. A read and a write on the same edge return the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data (ones select bits) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| periph_rst | output | 64 | Per-line reset, 1 = held in reset |
| clk_run | output | 64 | Per-line clock enable, 1 = clock runs |
| uart_div13 | output | 1 | Divide-by-13 reference select |

## Verification
A write takes effect in the state on the edge that samples it, so a read issued on the next cycle returns the new value one edge after that read. The `periph_rst`, `clk_run` and `uart_div13` outputs pass through one more register, so they are due on the second edge after the write. The bench drives its inputs on falling edges and waits exactly one rising edge for a read, and two for the outputs, before it samples on the next falling edge. A combined read-and-write cycle checks that the read returns the old value while the outputs still show the old state, and then the new state one edge later.

// File: rtl/sc_ctl_pkg.sv
package sc_ctl_pkg;

  localparam int WORD_W = 32;
  localparam int NLINES = 2 * WORD_W;
  localparam int NBANK  = 4;

  typedef enum logic [1:0] {
    BK_RST0 = 2'd0,
    BK_RST1 = 2'd1,
    BK_CLK0 = 2'd2,
    BK_CLK1 = 2'd3
  } bank_e;

  typedef struct packed {
    logic  hit;
    logic  clr;
    bank_e bank;
  } sc_dec_t;

  // Convert stored clock-stop bits into per-line run enables.
  function automatic logic [NLINES-1:0] run_of(
    input logic [NLINES-1:0] stop,
    input logic [NLINES-1:0] mask,
    input int inv_idx,
    input int div_idx
  );
    logic [NLINES-1:0] r;
    r = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (i == div_idx || !mask[i])
        r[i] = 1'b0;
      else if (i == inv_idx)
        r[i] = stop[i];
      else
        r[i] = ~stop[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/sc_addr_dec.sv
module sc_addr_dec
  import sc_ctl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RST_BASE = 'h040,
  parameter int CLK_BASE = 'h080,
  parameter int STRIDE   = 'h010,
  parameter int CLR_OFS  = 'h004
) (
  input  logic [ADDR_W-1:0] addr,
  output sc_dec_t           dec
);

  function automatic logic [ADDR_W-1:0] base_of(input int b);
    return ADDR_W'(((b < 2) ? RST_BASE : CLK_BASE) + (b % 2) * STRIDE);
  endfunction

  always_comb begin
    dec = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (addr == base_of(b)) begin
        dec.hit  = 1'b1;
        dec.clr  = 1'b0;
        dec.bank = bank_e'(b[1:0]);
      end else if (addr == base_of(b) + ADDR_W'(CLR_OFS)) begin
        dec.hit  = 1'b1;
        dec.clr  = 1'b1;
        dec.bank = bank_e'(b[1:0]);
      end
    end
  end

endmodule

// File: rtl/sc_word_reg.sv
module sc_word_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] MASK    = '1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] INIT = RST_VAL & MASK;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (set_en)
      nxt = q | din;
    else if (clr_en)
      nxt = q & ~din;
    nxt = nxt & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= INIT;
    else
      q <= nxt;
  end

endmodule

// File: rtl/sc_out_stage.sv
module sc_out_stage
  import sc_ctl_pkg::*;
#(
  parameter logic [NLINES-1:0] RST_MASK  = '1,
  parameter logic [NLINES-1:0] CLK_MASK  = '1,
  parameter logic [NLINES-1:0] CLK_INIT  = '1,
  parameter int                INV_IDX   = 14,
  parameter int                DIV_IDX   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] rst_state,
  input  logic [NLINES-1:0] stop_state,
  output logic [NLINES-1:0] periph_rst,
  output logic [NLINES-1:0] clk_run,
  output logic              div_sel
);

  localparam logic [NLINES-1:0] RUN_INIT  = run_of(CLK_INIT & CLK_MASK, CLK_MASK, INV_IDX, DIV_IDX);
  localparam logic              DIV_INIT  = CLK_INIT[DIV_IDX] & CLK_MASK[DIV_IDX];

  logic [NLINES-1:0] run_d;

  always_comb run_d = run_of(stop_state, CLK_MASK, INV_IDX, DIV_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      periph_rst <= RST_MASK;
      clk_run    <= RUN_INIT;
      div_sel    <= DIV_INIT;
    end else begin
      periph_rst <= rst_state;
      clk_run    <= run_d;
      div_sel    <= stop_state[DIV_IDX];
    end
  end

endmodule

// File: rtl/sc_ctl_bank.sv
module sc_ctl_bank
  import sc_ctl_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                RST_BASE = 'h040,
  parameter int                CLK_BASE = 'h080,
  parameter int                STRIDE   = 'h010,
  parameter int                CLR_OFS  = 'h004,
  parameter int                INV_IDX  = 14,
  parameter int                DIV_IDX  = 31,
  parameter logic [NLINES-1:0] RST_MASK = '1,
  parameter logic [NLINES-1:0] CLK_MASK = 64'h7FFF_FF37_8B30_E6FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [63:0]       periph_rst,
  output logic [63:0]       clk_run,
  output logic              uart_div13
);

  localparam logic [NLINES-1:0] CLK_INIT = ~(NLINES'(1) << INV_IDX);

  sc_dec_t wdec, rdec;
  logic [WORD_W-1:0] word_q [NBANK];

  sc_addr_dec #(
    .ADDR_W(ADDR_W), .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE),
    .STRIDE(STRIDE), .CLR_OFS(CLR_OFS)
  ) u_wdec (
    .addr(wr_addr),
    .dec (wdec)
  );

  sc_addr_dec #(
    .ADDR_W(ADDR_W), .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE),
    .STRIDE(STRIDE), .CLR_OFS(CLR_OFS)
  ) u_rdec (
    .addr(rd_addr),
    .dec (rdec)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_word
    localparam bit IS_RST = (b < 2);
    localparam int SLICE  = b % 2;
    localparam logic [WORD_W-1:0] W_MASK =
      IS_RST ? RST_MASK[SLICE*WORD_W +: WORD_W] : CLK_MASK[SLICE*WORD_W +: WORD_W];
    localparam logic [WORD_W-1:0] W_INIT =
      IS_RST ? '1 : CLK_INIT[SLICE*WORD_W +: WORD_W];

    logic sel;
    assign sel = wr_en && wdec.hit && (wdec.bank == bank_e'(b));

    sc_word_reg #(
      .W(WORD_W), .MASK(W_MASK), .RST_VAL(W_INIT)
    ) u_word (
      .clk   (clk),
      .rst   (rst),
      .set_en(sel && !wdec.clr),
      .clr_en(sel && wdec.clr),
      .din   (wr_data),
      .q     (word_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rdec.hit ? word_q[rdec.bank] : '0;
  end

  sc_out_stage #(
    .RST_MASK(RST_MASK), .CLK_MASK(CLK_MASK), .CLK_INIT(CLK_INIT),
    .INV_IDX(INV_IDX), .DIV_IDX(DIV_IDX)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .rst_state ({word_q[BK_RST1], word_q[BK_RST0]}),
    .stop_state({word_q[BK_CLK1], word_q[BK_CLK0]}),
    .periph_rst(periph_rst),
    .clk_run   (clk_run),
    .div_sel   (uart_div13)
  );

endmodule

// File: rtl/sc_ctl_bank_chk.sv
module sc_ctl_bank_chk #(
  parameter int          ADDR_W   = 12,
  parameter int          RST_BASE = 'h040,
  parameter int          CLK_BASE = 'h080,
  parameter int          STRIDE   = 'h010,
  parameter logic [63:0] RST_MASK = '1,
  parameter logic [63:0] CLK_MASK = 64'h7FFF_FF37_8B30_E6FF
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic [63:0]       periph_rst,
  input logic [63:0]       clk_run,
  input logic              uart_div13
);

  localparam logic [ADDR_W-1:0] A_R0 = ADDR_W'(RST_BASE);
  localparam logic [ADDR_W-1:0] A_R1 = ADDR_W'(RST_BASE + STRIDE);
  localparam logic [ADDR_W-1:0] A_C0 = ADDR_W'(CLK_BASE);
  localparam logic [ADDR_W-1:0] A_C1 = ADDR_W'(CLK_BASE + STRIDE);

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  function automatic logic mapped(input logic [ADDR_W-1:0] a);
    return (a == A_R0) || (a == A_R0 + 4) || (a == A_R1) || (a == A_R1 + 4) ||
           (a == A_C0) || (a == A_C0 + 4) || (a == A_C1) || (a == A_C1 + 4);
  endfunction

  // R2: ones written to reset word 0 set address appear on periph_rst two edges later
  a_r2_set_reaches_rst: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(wr_en, 2) && $past(wr_addr, 2) == A_R0) |->
      ((periph_rst[31:0] & $past(wr_data, 2) & RST_MASK[31:0]) ==
       ($past(wr_data, 2) & RST_MASK[31:0])));

  // R3: ones written to clock word 1 clear address start those clocks
  a_r3_clear_starts_clk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(wr_en, 2) && $past(wr_addr, 2) == A_C1 + 4) |->
      ((clk_run[63:32] & $past(wr_data, 2) & CLK_MASK[63:32]) ==
       ($past(wr_data, 2) & CLK_MASK[63:32])));

  // R5: reset outputs match the word read on the same edge
  a_r5_rst_matches_read: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(rd_addr) == A_R1) |-> (rd_data == periph_rst[63:32]));

  // R6: line 14 follows its bit, line 0 follows the inverse
  a_r6_polarity: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(rd_addr) == A_C0) |->
      (rd_data[14] == clk_run[14] && rd_data[0] == !clk_run[0]));

  // R7: bit 31 drives the divider select, never a clock
  a_r7_div_select: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(rd_addr) == A_C0) |->
      (uart_div13 == rd_data[31] && !clk_run[31]));

  // R8: tied-off clock lines read as zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && ($past(rd_addr) == A_C0 || $past(rd_addr) == A_C0 + 4)) |->
      ((rd_data & ~CLK_MASK[31:0]) == '0));

  // R10: undecoded reads return zero
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !mapped($past(rd_addr))) |-> (rd_data == '0));

  // R11: read data holds while no read is issued
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1 && !$past(rd_en)) |-> $stable(rd_data));

endmodule

bind sc_ctl_bank sc_ctl_bank_chk #(
  .ADDR_W(ADDR_W), .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE),
  .STRIDE(STRIDE), .RST_MASK(RST_MASK), .CLK_MASK(CLK_MASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .periph_rst(periph_rst), .clk_run(clk_run), .uart_div13(uart_div13)
);

// File: tb/sc_ctl_bank_test.sv
`timescale 1ns/1ps
module sc_ctl_bank_test;

  localparam logic [31:0] CM0 = 32'h8B30_E6FF;
  localparam logic [31:0] CM1 = 32'h7FFF_FF37;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] periph_rst, clk_run;
  logic        uart_div13;

  int total = 0;
  int bad   = 0;

  logic [31:0] mr0, mr1, mc0, mc1;

  always #4 clk = ~clk;

  sc_ctl_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .periph_rst(periph_rst), .clk_run(clk_run), .uart_div13(uart_div13)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h040, 12'h044: return mr0;
      12'h050, 12'h054: return mr1;
      12'h080, 12'h084: return mc0;
      12'h090, 12'h094: return mc1;
      default:          return 32'h0;
    endcase
  endfunction

  function automatic logic [63:0] exp_run();
    logic [63:0] stop, m, r;
    stop = {mc1, mc0};
    m    = {CM1, CM0};
    for (int i = 0; i < 64; i++) begin
      if (i == 31 || !m[i]) r[i] = 1'b0;
      else if (i == 14)     r[i] = stop[i];
      else                  r[i] = ~stop[i];
    end
    return r;
  endfunction

  task automatic model(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h040: mr0 = mr0 | d;
      12'h044: mr0 = mr0 & ~d;
      12'h050: mr1 = mr1 | d;
      12'h054: mr1 = mr1 & ~d;
      12'h080: mc0 = (mc0 | d) & CM0;
      12'h084: mc0 = mc0 & ~d;
      12'h090: mc1 = (mc1 | d) & CM1;
      12'h094: mc1 = mc1 & ~d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic chk_outs(input string req);
    chk({req, " periph_rst"}, periph_rst, {mr1, mr0});
    chk({req, " clk_run"}, clk_run, exp_run());
    chk({req, " div13"}, 64'(uart_div13), 64'(mc0[31]));
  endtask

  task automatic chk_rd(input string req, input logic [11:0] a);
    logic [31:0] v;
    rd(a, v);
    chk(req, 64'(v), 64'(exp_read(a)));
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] bases [4];
    logic [11:0] junk  [6];
    logic [31:0] v;
    bases[0] = 12'h040; bases[1] = 12'h050; bases[2] = 12'h080; bases[3] = 12'h090;
    junk[0] = 12'h048; junk[1] = 12'h060; junk[2] = 12'h081;
    junk[3] = 12'h0A0; junk[4] = 12'h000; junk[5] = 12'h098;

    mr0 = '1; mr1 = '1; mc0 = CM0 & ~(32'h1 << 14); mc1 = CM1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk_outs("R1");
    for (int b = 0; b < 4; b++) chk_rd("R1 read", bases[b]);

    // R4 / R5 / R6 / R8: single-bit sweep on every word
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 32; i++) begin
        wr(bases[b] + 12'h4, 32'hFFFF_FFFF);
        wr(bases[b], 32'h1 << i);
        @(negedge clk);
        chk_rd("R4 bit map", bases[b]);
        chk_outs(b < 2 ? "R5" : "R6 R8");
      end
    end

    // R2: set leaves zero-bit positions untouched
    wr(12'h054, 32'hFFFF_FFFF);
    wr(12'h050, 32'h5A5A_0F0F);
    wr(12'h050, 32'h0303_3000);
    @(negedge clk);
    chk_rd("R2 set merge", 12'h050);
    chk_outs("R2");

    // R3: clear leaves zero-bit positions untouched
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h084, 32'h0F0F_4001);
    @(negedge clk);
    chk_rd("R3 clear merge", 12'h080);
    chk_outs("R3");
    wr(12'h094, 32'h00FF_00F0);
    @(negedge clk);
    chk_rd("R3 clear word1", 12'h090);
    chk_outs("R3");

    // R9: clear addresses read like their set addresses
    for (int b = 0; b < 4; b++) chk_rd("R9 clear-addr read", bases[b] + 12'h4);

    // R7: divider select follows bit 31, clk_run[31] stays low
    wr(12'h084, 32'h8000_0000);
    @(negedge clk);
    chk_outs("R7 off");
    wr(12'h080, 32'h8000_0000);
    @(negedge clk);
    chk_outs("R7 on");

    // R10: undecoded writes change nothing, reads give zero
    for (int j = 0; j < 6; j++) wr(junk[j], 32'hFFFF_FFFF);
    for (int j = 0; j < 6; j++) wr(junk[j] + 12'h4, 32'hFFFF_FFFF);
    @(negedge clk);
    chk_outs("R10 outputs");
    for (int b = 0; b < 4; b++) chk_rd("R10 state", bases[b]);
    for (int j = 0; j < 6; j++) chk_rd("R10 read zero", junk[j]);

    // R11: read on write edge returns old value; outputs lag one more edge
    wr(12'h040, 32'hFFFF_FFFF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'h044; wr_data = 32'hFFFF_0000;
    rd_en = 1'b1; rd_addr = 12'h040;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read before write", 64'(rd_data), 64'(32'hFFFF_FFFF));
    chk("R11 outputs lag", periph_rst[31:0], 64'(32'hFFFF_FFFF));
    model(12'h044, 32'hFFFF_0000);
    @(negedge clk);
    chk("R11 outputs update", periph_rst[31:0], 64'(32'h0000_FFFF));
    chk("R11 read hold", 64'(rd_data), 64'(32'hFFFF_FFFF));
    chk_rd("R11 read after", 12'h040);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule